// File: doc/BRIEF.md
# Emulation Memory Dual-Port Arbiter

This block decides when a debug host controller may touch the emulation memory that the target processor also runs from. It takes the bus from the processor through the processor's bus-request line. It asks for the bus, waits for the processor to grant it, and hands the bus to the host. It hands the bus over only when no external DMA master is asking for the bus and the processor's current bus cycle has ended. While the processor sits in reset, the host gets the memory at once, without any arbitration.

A programmable request timeout guards the wait. If the bus is not free in time, the block raises a sticky dual-port error. In request mode it also fires a one-cycle force-reset pulse for the emulator. A lockout mode refuses host access while real-time emulation runs.

Separately, a watchdog follows each processor bus cycle. If an acknowledge never arrives, the watchdog can end the cycle after a programmable count. The block also says whether external DMA is currently allowed. It latches a configuration error when the acknowledge timeout is not longer than the request timeout.

The host side is a request/grant pair. `host_req` acts as valid and must stay high until `host_gnt` (ready) is seen. While `host_gnt` is high the host owns the memory. A one-cycle `host_done` hands the memory back. The host may drop `host_req` while waiting. After a fault the request must be dropped before a new one is accepted.

Top module: `dpa_arbiter`

## Requirements
- R1: After reset, `cpu_br`, `host_gnt`, `dp_err`, `force_rst`, `bus_abort`, `ack_tmo_flag` and `cfg_err` are all 0.
- R2: A request accepted from idle while `cpu_in_reset` is 0 raises `cpu_br` one cycle later. `host_gnt` rises one cycle after the first cycle in which `cpu_br` is high and either of two things holds: `cpu_in_reset` is 1, or `cpu_bg`=1, `dma_req`=0 and `cpu_as`=0 all hold together.
- R3: A request accepted from idle while `cpu_in_reset` is 1 raises `host_gnt` one cycle later with `cpu_br` held at 0.
- R4: If the grant condition of R2 fails in `req_tmo`+1 consecutive cycles of `cpu_br`, three things happen on the next cycle. `cpu_br` drops, `dp_err` rises and stays high until reset, and no grant is given until `host_req` has been seen low.
- R5: The error of R4 produces a one-cycle `force_rst` pulse, in the same cycle as `dp_err` rises, when `req_mode` is 1. When `req_mode` is 0 it produces no pulse.
- R6: While `denied` and `rt_run` are both 1, a request in idle is not accepted: `cpu_br` and `host_gnt` stay 0.
- R7: `host_gnt` and `cpu_br` hold until a cycle with `host_done`=1. Both are 0 in the following cycle.
- R8: With `ack_tmo_en`=1, a bus cycle that keeps `cpu_as`=1 and `cpu_dtack`=0 for `ack_tmo`+1 cycles gives a one-cycle `bus_abort` pulse. The same event sets the sticky `ack_tmo_flag`. With `ack_tmo_en`=0 a missing acknowledge never aborts. `cpu_as`=0 restarts the count.
- R9: `dma_allow` equals `dma_always` OR `rt_run`, with no register delay.
- R10: `cfg_err` is set one cycle after a cycle in which `ack_tmo_en`=1 and `ack_tmo` <= `req_tmo`. It stays set until reset.
- R11: The request timeout count restarts with every new request. Two requests that each wait fewer than `req_tmo`+1 cycles raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as | input | 1 | Processor bus cycle in progress (address strobe, active high) |
| cpu_dtack | input | 1 | Bus cycle acknowledge (active high) |
| cpu_bg | input | 1 | Bus grant from the processor |
| cpu_in_reset | input | 1 | Processor held in reset |
| dma_req | input | 1 | External DMA bus request pending |
| rt_run | input | 1 | Real-time emulation running |
| denied | input | 1 | Lockout mode: no host access during real-time runs |
| dma_always | input | 1 | Allow external DMA at all times |
| req_mode | input | 1 | Request mode: a dual-port error forces reset |
| req_tmo | input | 8 | Request timeout, in clocks |
| ack_tmo | input | 8 | Acknowledge timeout, in clocks |
| ack_tmo_en | input | 1 | Enable the acknowledge timeout |
| host_req | input | 1 | Host request (valid) |
| host_done | input | 1 | Host access finished |
| cpu_br | output | 1 | Bus request to the processor |
| host_gnt | output | 1 | Host grant (ready) |
| dp_err | output | 1 | Sticky dual-port error |
| force_rst | output | 1 | One-cycle force-reset request |
| bus_abort | output | 1 | One-cycle termination of a timed-out bus cycle |
| ack_tmo_flag | output | 1 | Sticky acknowledge-timeout status |
| dma_allow | output | 1 | External DMA permitted |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench targets several edges, each with its typical failure.

- **Grant condition.** It holds one blocker of the grant condition at a time: bus grant missing, address strobe high, DMA pending. A design that ignored any one of them would grant early.
- **Timeout boundary.** It drives the request timeout to its exact edge. An off-by-one counter would flag the error one cycle early or late.
- **Counter restart.** Back-to-back requests that each wait just short of the limit catch a counter that is not cleared per request.
- **Fault handling.** After a fault it checks that the request must be dropped before a new grant. It checks that the force-reset pulse depends on request mode.
- **Acknowledge watchdog.** It checks that the watchdog stays silent when disabled and restarts on a new bus cycle.
- **Reset path.** It checks that the reset path grants without raising the bus request.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned TMO_W = 8;

  typedef enum logic [2:0] {
    ARB_IDLE   = 3'd0,
    ARB_WAIT   = 3'd1,
    ARB_HOLD   = 3'd2,
    ARB_DIRECT = 3'd3,
    ARB_FAULT  = 3'd4
  } arb_state_e;

  typedef struct packed {
    logic denied;
    logic req_mode;
    logic dma_always;
    logic ack_tmo_en;
  } dpa_cfg_t;
endpackage

// File: rtl/dpa_req_arbiter.sv
module dpa_req_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned CNT_W = TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_as,
  input  logic             cpu_bg,
  input  logic             cpu_in_reset,
  input  logic             dma_req,
  input  logic             rt_run,
  input  dpa_cfg_t         cfg,
  input  logic [CNT_W-1:0] req_tmo,
  input  logic             host_req,
  input  logic             host_done,
  output logic             cpu_br,
  output logic             host_gnt,
  output logic             dp_err,
  output logic             force_rst
);
  arb_state_e       state_q, state_d;
  logic [CNT_W-1:0] wait_cnt_q, wait_cnt_d;
  logic             err_q, err_d;
  logic             frst_q, frst_d;
  logic             lockout;
  logic             bus_free;
  logic             expired;

  // host may not start while real-time emulation runs in lockout mode
  assign lockout  = cfg.denied & rt_run;
  // bus may be used when the processor is in reset or the bus is released
  assign bus_free = cpu_in_reset | (cpu_bg & ~dma_req & ~cpu_as);
  assign expired  = (wait_cnt_q == req_tmo);

  always_comb begin
    state_d    = state_q;
    wait_cnt_d = wait_cnt_q;
    err_d      = err_q;
    frst_d     = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (host_req && !lockout) begin
          wait_cnt_d = '0;
          state_d    = cpu_in_reset ? ARB_DIRECT : ARB_WAIT;
        end
      end
      ARB_WAIT: begin
        if (bus_free) begin
          state_d = ARB_HOLD;
        end else if (expired) begin
          state_d = ARB_FAULT;
          err_d   = 1'b1;
          frst_d  = cfg.req_mode;
        end else begin
          wait_cnt_d = wait_cnt_q + 1'b1;
        end
      end
      ARB_HOLD, ARB_DIRECT: begin
        if (host_done) state_d = ARB_IDLE;
      end
      ARB_FAULT: begin
        if (!host_req) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ARB_IDLE;
      wait_cnt_q <= '0;
      err_q      <= 1'b0;
      frst_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      wait_cnt_q <= wait_cnt_d;
      err_q      <= err_d;
      frst_q     <= frst_d;
    end
  end

  assign cpu_br    = (state_q == ARB_WAIT) || (state_q == ARB_HOLD);
  assign host_gnt  = (state_q == ARB_HOLD) || (state_q == ARB_DIRECT);
  assign dp_err    = err_q;
  assign force_rst = frst_q;
endmodule

// File: rtl/dpa_ack_watch.sv
module dpa_ack_watch
  import dpa_pkg::*;
#(
  parameter int unsigned CNT_W = TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_as,
  input  logic             cpu_dtack,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  output logic             abort_pulse,
  output logic             tmo_flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             abort_q;
  logic             flag_q;
  logic             stalled;

  assign stalled = cpu_as & ~cpu_dtack & enable & ~fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      abort_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (!cpu_as) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (stalled) begin
        if (cnt_q == limit) begin
          abort_q <= 1'b1;
          fired_q <= 1'b1;
          flag_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign abort_pulse = abort_q;
  assign tmo_flag    = flag_q;
endmodule

// File: rtl/dpa_cfg_guard.sv
module dpa_cfg_guard
  import dpa_pkg::*;
#(
  parameter int unsigned CNT_W = TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpa_cfg_t         cfg,
  input  logic             rt_run,
  input  logic [CNT_W-1:0] req_tmo,
  input  logic [CNT_W-1:0] ack_tmo,
  output logic             dma_allow,
  output logic             cfg_err
);
  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (cfg.ack_tmo_en && (ack_tmo <= req_tmo)) begin
      err_q <= 1'b1;
    end
  end

  assign cfg_err   = err_q;
  assign dma_allow = cfg.dma_always | rt_run;
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned CNT_W = TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_as,
  input  logic             cpu_dtack,
  input  logic             cpu_bg,
  input  logic             cpu_in_reset,
  input  logic             dma_req,
  input  logic             rt_run,
  input  logic             denied,
  input  logic             dma_always,
  input  logic             req_mode,
  input  logic [CNT_W-1:0] req_tmo,
  input  logic [CNT_W-1:0] ack_tmo,
  input  logic             ack_tmo_en,
  input  logic             host_req,
  input  logic             host_done,
  output logic             cpu_br,
  output logic             host_gnt,
  output logic             dp_err,
  output logic             force_rst,
  output logic             bus_abort,
  output logic             ack_tmo_flag,
  output logic             dma_allow,
  output logic             cfg_err
);
  dpa_cfg_t cfg;

  always_comb begin
    cfg.denied     = denied;
    cfg.req_mode   = req_mode;
    cfg.dma_always = dma_always;
    cfg.ack_tmo_en = ack_tmo_en;
  end

  dpa_req_arbiter #(.CNT_W(CNT_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_as       (cpu_as),
    .cpu_bg       (cpu_bg),
    .cpu_in_reset (cpu_in_reset),
    .dma_req      (dma_req),
    .rt_run       (rt_run),
    .cfg          (cfg),
    .req_tmo      (req_tmo),
    .host_req     (host_req),
    .host_done    (host_done),
    .cpu_br       (cpu_br),
    .host_gnt     (host_gnt),
    .dp_err       (dp_err),
    .force_rst    (force_rst)
  );

  dpa_ack_watch #(.CNT_W(CNT_W)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_as      (cpu_as),
    .cpu_dtack   (cpu_dtack),
    .enable      (ack_tmo_en),
    .limit       (ack_tmo),
    .abort_pulse (bus_abort),
    .tmo_flag    (ack_tmo_flag)
  );

  dpa_cfg_guard #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .rt_run    (rt_run),
    .req_tmo   (req_tmo),
    .ack_tmo   (ack_tmo),
    .dma_allow (dma_allow),
    .cfg_err   (cfg_err)
  );
endmodule

// File: rtl/dpa_arbiter_chk.sv
module dpa_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_as,
  input logic cpu_bg,
  input logic cpu_in_reset,
  input logic dma_req,
  input logic rt_run,
  input logic denied,
  input logic host_done,
  input logic cpu_br,
  input logic host_gnt,
  input logic dp_err,
  input logic force_rst,
  input logic bus_abort,
  input logic ack_tmo_flag,
  input logic cfg_err
);
  // R2
  grant_needs_free_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) && cpu_br |->
      $past(cpu_in_reset || (cpu_bg && !dma_req && !cpu_as)));

  // R3
  direct_grant_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) && !cpu_br && !$past(cpu_br) |-> $past(cpu_in_reset));

  // R4
  fault_drops_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_err) |-> !cpu_br && !host_gnt);

  // R4
  fault_is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_err |=> dp_err);

  // R5
  force_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |-> $rose(dp_err) ##1 !force_rst);

  // R6
  lockout_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_br) |-> !$past(denied && rt_run));

  // R7
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt && host_done |=> !host_gnt && !cpu_br);

  // R8
  abort_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> ack_tmo_flag ##1 !bus_abort);

  // R10
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind dpa_arbiter dpa_arbiter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_as       (cpu_as),
  .cpu_bg       (cpu_bg),
  .cpu_in_reset (cpu_in_reset),
  .dma_req      (dma_req),
  .rt_run       (rt_run),
  .denied       (denied),
  .host_done    (host_done),
  .cpu_br       (cpu_br),
  .host_gnt     (host_gnt),
  .dp_err       (dp_err),
  .force_rst    (force_rst),
  .bus_abort    (bus_abort),
  .ack_tmo_flag (ack_tmo_flag),
  .cfg_err      (cfg_err)
);

// File: tb/dpa_arbiter_test.sv
module dpa_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_as = 0, cpu_dtack = 0, cpu_bg = 0, cpu_in_reset = 0, dma_req = 0;
  logic rt_run = 0, denied = 0, dma_always = 0, req_mode = 0, ack_tmo_en = 0;
  logic [7:0] req_tmo = 8'd5, ack_tmo = 8'd20;
  logic host_req = 0, host_done = 0;
  logic cpu_br, host_gnt, dp_err, force_rst, bus_abort, ack_tmo_flag, dma_allow, cfg_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dpa_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cpu_as(cpu_as), .cpu_dtack(cpu_dtack), .cpu_bg(cpu_bg),
    .cpu_in_reset(cpu_in_reset), .dma_req(dma_req), .rt_run(rt_run), .denied(denied),
    .dma_always(dma_always), .req_mode(req_mode), .req_tmo(req_tmo), .ack_tmo(ack_tmo),
    .ack_tmo_en(ack_tmo_en), .host_req(host_req), .host_done(host_done),
    .cpu_br(cpu_br), .host_gnt(host_gnt), .dp_err(dp_err), .force_rst(force_rst),
    .bus_abort(bus_abort), .ack_tmo_flag(ack_tmo_flag), .dma_allow(dma_allow),
    .cfg_err(cfg_err)
  );

  // behavioural reference: phase 0 idle, 1 asking, 2 owned via bus, 3 owned in reset, 4 faulted
  int  m_phase = 0;
  int  m_wait = 0;
  int  m_ack = 0;
  bit  m_fired = 0;
  bit  m_br = 0, m_gnt = 0, m_err = 0, m_frst = 0, m_abort = 0, m_flag = 0, m_cerr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_ack = 0; m_fired = 0;
      m_err = 0; m_frst = 0; m_abort = 0; m_flag = 0; m_cerr = 0;
    end else begin
      m_frst = 0;
      m_abort = 0;
      if (m_phase == 0) begin
        if (host_req && !(denied && rt_run)) begin
          m_wait = 0;
          m_phase = cpu_in_reset ? 3 : 1;
        end
      end else if (m_phase == 1) begin
        if (cpu_in_reset || (cpu_bg && !dma_req && !cpu_as)) m_phase = 2;
        else if (m_wait == int'(req_tmo)) begin
          m_phase = 4; m_err = 1; m_frst = req_mode;
        end else m_wait++;
      end else if (m_phase == 2 || m_phase == 3) begin
        if (host_done) m_phase = 0;
      end else if (!host_req) m_phase = 0;
      if (!cpu_as) begin
        m_ack = 0; m_fired = 0;
      end else if (ack_tmo_en && !cpu_dtack && !m_fired) begin
        if (m_ack == int'(ack_tmo)) begin
          m_abort = 1; m_fired = 1; m_flag = 1;
        end else m_ack++;
      end
      if (ack_tmo_en && ack_tmo <= req_tmo) m_cerr = 1;
    end
    m_br  = (m_phase == 1 || m_phase == 2);
    m_gnt = (m_phase == 2 || m_phase == 3);
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(cpu_br, m_br, "R2 cpu_br");
      chk(host_gnt, m_gnt, "R7 host_gnt");
      chk(dp_err, m_err, "R4 dp_err");
      chk(force_rst, m_frst, "R5 force_rst");
      chk(bus_abort, m_abort, "R8 bus_abort");
      chk(ack_tmo_flag, m_flag, "R8 ack_tmo_flag");
      chk(dma_allow, dma_always | rt_run, "R9 dma_allow");
      chk(cfg_err, m_cerr, "R10 cfg_err");
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    // R1 reset values
    chk(cpu_br | host_gnt | dp_err | force_rst | bus_abort | ack_tmo_flag | cfg_err, 1'b0, "R1 reset outputs");
    rst_n = 1;
    cyc(1);

    // R2 normal grant after bus grant arrives
    host_req = 1; cyc(1);
    chk(cpu_br, 1'b1, "R2 br raised");
    cyc(2);
    cpu_bg = 1; cyc(1);
    chk(host_gnt, 1'b1, "R2 granted");
    host_req = 0; cyc(1);
    host_done = 1; cyc(1);
    host_done = 0;
    chk(host_gnt | cpu_br, 1'b0, "R7 released after done");
    cyc(1);

    // R2 address strobe and DMA each block the grant
    cpu_as = 1; cpu_dtack = 0; host_req = 1; cyc(3);
    chk(host_gnt, 1'b0, "R2 held by open bus cycle");
    cpu_as = 0; dma_req = 1; cyc(2);
    chk(host_gnt, 1'b0, "R2 held by dma");
    dma_req = 0; cyc(2);
    host_req = 0; host_done = 1; cyc(1); host_done = 0; cyc(1);

    // R11 two requests each waiting req_tmo cycles, no error
    cpu_bg = 0;
    for (int k = 0; k < 2; k++) begin
      host_req = 1; cyc(5);
      cpu_bg = 1; cyc(1);
      cpu_bg = 0; host_req = 0; host_done = 1; cyc(1); host_done = 0; cyc(1);
    end
    chk(dp_err, 1'b0, "R11 counter restarts per request");

    // R4/R5 timeout with request mode
    req_mode = 1; dma_req = 1; cpu_bg = 1; host_req = 1;
    cyc(8);
    chk(dp_err, 1'b1, "R4 error after timeout");
    cpu_in_reset = 1; dma_req = 0; cyc(3);
    chk(host_gnt, 1'b0, "R4 no grant while request stays high");
    host_req = 0; cyc(1);

    // R3 direct grant in reset
    host_req = 1; cpu_bg = 0; cyc(1);
    chk(host_gnt & ~cpu_br, 1'b1, "R3 grant without br");
    host_req = 0; host_done = 1; cyc(1); host_done = 0; cpu_in_reset = 0; cyc(1);

    do_reset();
    // R5 timeout without request mode, req_tmo 0
    req_mode = 0; req_tmo = 8'd0; host_req = 1; cyc(4);
    chk(force_rst, 1'b0, "R5 no force pulse");
    host_req = 0; cyc(2);
    req_tmo = 8'd5;

    do_reset();
    // R6 lockout
    denied = 1; rt_run = 1; host_req = 1; cyc(4);
    chk(cpu_br | host_gnt, 1'b0, "R6 locked out");
    rt_run = 0; cyc(1);
    chk(cpu_br, 1'b1, "R6 accepted when not running");
    cpu_bg = 1; cyc(1);
    host_req = 0; host_done = 1; cyc(1); host_done = 0; denied = 0; cpu_bg = 0; cyc(1);

    // R9 dma permission combinations
    dma_always = 1; cyc(1); dma_always = 0; rt_run = 1; cyc(1); rt_run = 0; cyc(1);

    // R8 watchdog disabled then enabled
    cpu_as = 1; cyc(30);
    chk(bus_abort | ack_tmo_flag, 1'b0, "R8 disabled never aborts");
    cpu_as = 0; ack_tmo_en = 1; ack_tmo = 8'd6; cyc(1);
    cpu_as = 1; cyc(3); cpu_as = 0; cyc(1);
    chk(ack_tmo_flag, 1'b0, "R8 restart on new cycle");
    cpu_as = 1; cyc(10);
    chk(ack_tmo_flag, 1'b1, "R8 timeout flagged");
    cpu_as = 0; cyc(1);
    chk(cfg_err, 1'b0, "R10 valid config");

    // R10 configuration error
    ack_tmo = 8'd5; cyc(1);
    ack_tmo = 8'd40; cyc(2);
    chk(cfg_err, 1'b1, "R10 latched");
    ack_tmo_en = 0;
    cyc(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule